// File: doc/BRIEF.md
# Per-CPU Masked Device Interrupt Router

This block gathers up to 64 level-sensitive device interrupt lines into one shared raw request register. Four CPUs each own a 64-bit mask, and each gets one hard interrupt output that is raised whenever any unmasked raw request is pending for it. One raw bit (position 55) is reserved for the output of a cascaded legacy interrupt controller. The line of the device vector at that position is not used.

Software reaches the block through a simple CSR port addressed by a 12-bit byte offset. It can read the raw request register, each CPU's mask and each CPU's masked request, and it can write the masks. Reads complete one cycle after the request. An access to an offset the block does not implement returns all ones and pulses an error flag.

Top module: `irqr_router`

## Requirements
- R1: The raw request register (read at offset 0x300) samples the device lines on every clock edge, so bit i is 1 while line i is high and 0 while it is low, one cycle behind the pins.
- R2: Raw bit 55 is taken from `legacy_irq_i`, and `dev_irq_i[55]` has no effect on the raw register or on any output.
- R3: The mask for CPU n sits at offset 0x200, 0x240, 0x600 or 0x640 (n = 0..3). It resets to zero, is written as a full 64-bit word, and a write to mask n leaves every other mask unchanged.
- R4: A read at offset 0x280, 0x2C0, 0x680 or 0x6C0 returns the mask of CPU 0..3 ANDed with the raw request register.
- R5: `irq_o[n]` is 1 exactly when the masked request of CPU n is nonzero, and it follows a change of the raw register or of a mask one clock later.
- R6: Writes to the masked request offsets and to the raw offset change nothing and do not raise the error flag.
- R7: An access to any other offset reads as all ones, raises `csr_err_o` for the following cycle, and a write there changes no mask.
- R8: `csr_rdata_o` is loaded on the edge that accepts a read and holds its value until the next read. `csr_err_o` is high only in the cycle after an erroneous access.
- R9: After reset `irq_o`, `csr_err_o` and `csr_rdata_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dev_irq_i | input | 64 | Level device interrupt lines (bit 55 unused) |
| legacy_irq_i | input | 1 | Cascaded legacy controller output, drives raw bit 55 |
| csr_req_i | input | 1 | CSR access request, one cycle per access |
| csr_we_i | input | 1 | 1 for a write, 0 for a read |
| csr_addr_i | input | 12 | Byte offset of the access |
| csr_wdata_i | input | 64 | Write data |
| csr_rdata_o | output | 64 | Read data, valid the cycle after a read |
| csr_err_o | output | 1 | Pulses after an access to an unimplemented offset |
| irq_o | output | 4 | Hard interrupt output per CPU |

## Verification
The assertions assume that the device lines and the legacy input change only between clock edges. They also assume that each CSR request lasts one cycle and carries an offset that is stable while it is sampled. The bench drives every input on the falling edge and holds the lines steady for at least two edges before it reads the raw or masked registers, so the expected values follow directly from the levels it drove. The checks on the interrupt outputs are also made only after the lines have been idle or steady for two edges, which matches the latency the assertions take for granted.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

    localparam int unsigned CSR_AW = 12;
    localparam logic [CSR_AW-1:0] RAW_OFF = 12'h300;

    typedef enum logic [1:0] {
        K_NONE   = 2'd0,
        K_MASK   = 2'd1,
        K_MASKED = 2'd2,
        K_RAW    = 2'd3
    } csr_kind_e;

    // Mask offsets: pairs of CPUs share a 1 KiB page, 0x40 apart.
    function automatic logic [CSR_AW-1:0] mask_off(input int unsigned n);
        return CSR_AW'(32'h200 + (n / 2) * 32'h400 + (n % 2) * 32'h40);
    endfunction

    function automatic logic [CSR_AW-1:0] masked_off(input int unsigned n);
        return mask_off(n) + CSR_AW'(12'h080);
    endfunction

endpackage

// File: rtl/irqr_decode.sv
module irqr_decode
    import irqr_pkg::*;
#(
    parameter int unsigned NUM_CPU = 4,
    localparam int unsigned CW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic [CSR_AW-1:0] addr_i,
    output csr_kind_e         kind_o,
    output logic [CW-1:0]     cpu_o
);

    always_comb begin
        kind_o = K_NONE;
        cpu_o  = '0;
        if (addr_i == RAW_OFF) begin
            kind_o = K_RAW;
        end
        for (int n = 0; n < NUM_CPU; n++) begin
            if (addr_i == mask_off(n)) begin
                kind_o = K_MASK;
                cpu_o  = CW'(n);
            end
            if (addr_i == masked_off(n)) begin
                kind_o = K_MASKED;
                cpu_o  = CW'(n);
            end
        end
    end

endmodule

// File: rtl/irqr_raw_capture.sv
module irqr_raw_capture #(
    parameter int unsigned LINES      = 64,
    parameter int unsigned LEGACY_BIT = 55
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LINES-1:0] lines_i,
    input  logic             legacy_i,
    output logic [LINES-1:0] raw_o
);

    logic [LINES-1:0] raw_d, raw_q;

    always_comb begin
        raw_d             = lines_i;
        raw_d[LEGACY_BIT] = legacy_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) raw_q <= '0;
        else         raw_q <= raw_d;
    end

    assign raw_o = raw_q;

endmodule

// File: rtl/irqr_cpu_slice.sv
module irqr_cpu_slice #(
    parameter int unsigned LINES = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [LINES-1:0] wdata_i,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] mask_o,
    output logic [LINES-1:0] pend_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [LINES-1:0] mask;
        logic             irq;
    } slice_t;

    slice_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.irq  = |(st_q.mask & raw_i);
        if (wr_en_i) st_d.mask = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign mask_o = st_q.mask;
    assign pend_o = st_q.mask & raw_i;
    assign irq_o  = st_q.irq;

endmodule

// File: rtl/irqr_router.sv
module irqr_router
    import irqr_pkg::*;
#(
    parameter int unsigned LINES      = 64,
    parameter int unsigned NUM_CPU    = 4,
    parameter int unsigned LEGACY_BIT = 55,
    localparam int unsigned CW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [LINES-1:0]   dev_irq_i,
    input  logic               legacy_irq_i,
    input  logic               csr_req_i,
    input  logic               csr_we_i,
    input  logic [CSR_AW-1:0]  csr_addr_i,
    input  logic [LINES-1:0]   csr_wdata_i,
    output logic [LINES-1:0]   csr_rdata_o,
    output logic               csr_err_o,
    output logic [NUM_CPU-1:0] irq_o
);

    typedef struct packed {
        logic [LINES-1:0] rdata;
        logic             err;
    } csr_t;

    csr_t             csr_d, csr_q;
    csr_kind_e        kind;
    logic [CW-1:0]    cpu_sel;
    logic [LINES-1:0] raw;
    logic [LINES-1:0] mask_arr [NUM_CPU];
    logic [LINES-1:0] pend_arr [NUM_CPU];
    logic [LINES-1:0] rd_value;

    irqr_decode #(.NUM_CPU(NUM_CPU)) u_decode (
        .addr_i (csr_addr_i),
        .kind_o (kind),
        .cpu_o  (cpu_sel)
    );

    irqr_raw_capture #(.LINES(LINES), .LEGACY_BIT(LEGACY_BIT)) u_raw (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .lines_i  (dev_irq_i),
        .legacy_i (legacy_irq_i),
        .raw_o    (raw)
    );

    for (genvar n = 0; n < NUM_CPU; n++) begin : g_cpu
        logic wr_en;
        assign wr_en = csr_req_i && csr_we_i && (kind == K_MASK) && (cpu_sel == CW'(n));

        irqr_cpu_slice #(.LINES(LINES)) u_slice (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .wr_en_i (wr_en),
            .wdata_i (csr_wdata_i),
            .raw_i   (raw),
            .mask_o  (mask_arr[n]),
            .pend_o  (pend_arr[n]),
            .irq_o   (irq_o[n])
        );
    end

    always_comb begin
        rd_value = '1;
        unique case (kind)
            K_MASK:   rd_value = mask_arr[cpu_sel];
            K_MASKED: rd_value = pend_arr[cpu_sel];
            K_RAW:    rd_value = raw;
            default:  rd_value = '1;
        endcase

        csr_d     = csr_q;
        csr_d.err = 1'b0;
        if (csr_req_i) begin
            csr_d.err = (kind == K_NONE);
            if (!csr_we_i) csr_d.rdata = rd_value;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) csr_q <= '0;
        else         csr_q <= csr_d;
    end

    assign csr_rdata_o = csr_q.rdata;
    assign csr_err_o   = csr_q.err;

endmodule

// File: rtl/irqr_checker.sv
module irqr_checker #(
    parameter int unsigned LINES      = 64,
    parameter int unsigned NUM_CPU    = 4,
    parameter int unsigned LEGACY_BIT = 55
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [LINES-1:0]   dev_irq_i,
    input logic               legacy_irq_i,
    input logic               csr_req_i,
    input logic               csr_we_i,
    input logic [11:0]        csr_addr_i,
    input logic [LINES-1:0]   csr_rdata_o,
    input logic               csr_err_o,
    input logic [NUM_CPU-1:0] irq_o
);

    logic [1:0]       cyc;
    logic [LINES-1:0] exp_raw;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    always_comb begin
        exp_raw             = dev_irq_i;
        exp_raw[LEGACY_BIT] = legacy_irq_i;
    end

    function automatic logic known(input logic [11:0] a);
        logic page_ok, slot_ok;
        page_ok = (a[11:8] == 4'h2) || (a[11:8] == 4'h6);
        slot_ok = (a[5:0] == 6'h00);
        return (a == 12'h300) || (page_ok && slot_ok);
    endfunction

    // R5: no pending lines for two edges means every CPU output is low
    assert_irq_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc == 2'd3 && $past(exp_raw == '0) && $past(exp_raw == '0, 2)) |-> (irq_o == '0));

    // R7: unimplemented read returns all ones with an error pulse
    assert_unimpl_ones_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_req_i && !csr_we_i && !known(csr_addr_i)) |=> (csr_rdata_o == '1 && csr_err_o));

    // R6: writes to implemented offsets, read-only ones included, raise no error
    assert_ro_no_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_req_i && csr_we_i && known(csr_addr_i)) |=> !csr_err_o);

    // R1: raw register readback equals the pin levels two edges back
    assert_raw_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc == 2'd3 && csr_req_i && !csr_we_i && csr_addr_i == 12'h300)
        |=> (csr_rdata_o == $past(exp_raw, 2)));

    // R8: the error flag is only a response to an access
    assert_err_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !csr_req_i |=> !csr_err_o);

endmodule

bind irqr_router irqr_checker #(
    .LINES(LINES), .NUM_CPU(NUM_CPU), .LEGACY_BIT(LEGACY_BIT)
) u_irqr_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dev_irq_i    (dev_irq_i),
    .legacy_irq_i (legacy_irq_i),
    .csr_req_i    (csr_req_i),
    .csr_we_i     (csr_we_i),
    .csr_addr_i   (csr_addr_i),
    .csr_rdata_o  (csr_rdata_o),
    .csr_err_o    (csr_err_o),
    .irq_o        (irq_o)
);

// File: tb/test_irqr_router.sv
`timescale 1ns/1ps
module test_irqr_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] dev = '0;
    logic        leg = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        err;
    logic [3:0]  irq;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [63:0] exp_data_q [$];
    logic        exp_err_q  [$];
    string       exp_tag_q  [$];
    logic        pend = 1'b0;

    logic [63:0] mask_m [4];
    logic [11:0] mask_a [4] = '{12'h200, 12'h240, 12'h600, 12'h640};
    logic [11:0] pend_a [4] = '{12'h280, 12'h2C0, 12'h680, 12'h6C0};

    always #10 clk = ~clk;

    irqr_router i_irqr_router (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .dev_irq_i    (dev),
        .legacy_irq_i (leg),
        .csr_req_i    (req),
        .csr_we_i     (we),
        .csr_addr_i   (addr),
        .csr_wdata_i  (wdata),
        .csr_rdata_o  (rdata),
        .csr_err_o    (err),
        .irq_o        (irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] raw_of(input logic [63:0] d, input logic l);
        logic [63:0] r;
        r = d;
        r[55] = l;
        return r;
    endfunction

    // Monitor: pops one expectation per accepted read
    always @(posedge clk) pend <= req && !we;
    always @(negedge clk) begin
        if (pend && exp_data_q.size() > 0) begin
            logic [63:0] ed;
            logic        ee;
            string       et;
            ed = exp_data_q.pop_front();
            ee = exp_err_q.pop_front();
            et = exp_tag_q.pop_front();
            chk(rdata == ed, et, rdata, ed);
            chk(err == ee, {et, " err"}, 64'(err), 64'(ee));
        end
    end

    // Driver: read with expected result pushed to the scoreboard
    task automatic rd(input logic [11:0] a, input logic [63:0] e, input logic ee, input string tag);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a;
        exp_data_q.push_back(e);
        exp_err_q.push_back(ee);
        exp_tag_q.push_back(tag);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d, output logic e);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        e = err;
        req = 1'b0; we = 1'b0;
    endtask

    task automatic set_lines(input logic [63:0] d, input logic l);
        @(negedge clk);
        dev = d; leg = l;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_masks(input string tag);
        for (int n = 0; n < 4; n++) rd(mask_a[n], mask_m[n], 1'b0, tag);
    endtask

    task automatic check_pend_irq(input string tag);
        logic [63:0] r;
        logic [3:0]  ei;
        r = raw_of(dev, leg);
        ei = '0;
        for (int n = 0; n < 4; n++) begin
            rd(pend_a[n], mask_m[n] & r, 1'b0, {"R4 ", tag});
            ei[n] = |(mask_m[n] & r);
        end
        chk(irq == ei, {"R5 ", tag}, 64'(irq), 64'(ei));
    endtask

    initial begin
        logic e;
        for (int n = 0; n < 4; n++) mask_m[n] = '0;
        repeat (3) @(negedge clk);
        chk(irq == 4'h0, "R9 irq", 64'(irq), 64'h0);
        chk(err == 1'b0, "R9 err", 64'(err), 64'h0);
        chk(rdata == '0, "R9 rdata", rdata, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        check_masks("R3 reset masks");

        // R1: raw tracks levels
        set_lines(64'hA5A5_0000_1234_8001, 1'b0);
        rd(12'h300, raw_of(dev, leg), 1'b0, "R1 raw pattern A");
        set_lines(64'h0000_0000_0000_0000, 1'b0);
        rd(12'h300, 64'h0, 1'b0, "R1 raw cleared");

        // R2: bit 55 comes only from the legacy input
        set_lines(64'h0080_0000_0000_0000, 1'b0);
        rd(12'h300, 64'h0, 1'b0, "R2 dev bit55 ignored");
        set_lines(64'h0000_0000_0000_0000, 1'b1);
        rd(12'h300, 64'h0080_0000_0000_0000, 1'b0, "R2 legacy sets bit55");

        // R3: mask writes are independent
        wr(12'h200, 64'h0000_0000_0000_00FF, e); mask_m[0] = 64'hFF;
        chk(e == 1'b0, "R3 mask write no err", 64'(e), 64'h0);
        wr(12'h600, 64'h0080_0000_0000_0000, e); mask_m[2] = 64'h0080_0000_0000_0000;
        check_masks("R3 after two writes");
        wr(12'h640, 64'hFFFF_FFFF_FFFF_FFFF, e); mask_m[3] = '1;
        check_masks("R3 mask3 full");

        // R4/R5 under several line patterns
        set_lines(64'h0, 1'b1);
        check_pend_irq("legacy only");
        set_lines(64'h0000_0000_0000_0010, 1'b0);
        check_pend_irq("low line");
        set_lines(64'h8000_0000_0000_0000, 1'b0);
        check_pend_irq("top line");

        // R5 latency: line rises, output follows one edge after the raw register
        set_lines(64'h0, 1'b0);
        wr(12'h640, 64'h0, e); mask_m[3] = '0;
        @(negedge clk);
        dev = 64'h8;
        @(negedge clk);
        chk(irq == 4'h0, "R5 not yet after one edge", 64'(irq), 64'h0);
        @(negedge clk);
        chk(irq == 4'h1, "R5 raised after two edges", 64'(irq), 64'h1);
        // mask cleared: output drops one edge after the mask register
        wr(12'h200, 64'h0, e); mask_m[0] = '0;
        chk(irq == 4'h1, "R5 mask change not yet seen", 64'(irq), 64'h1);
        @(negedge clk);
        chk(irq == 4'h0, "R5 dropped after mask clear", 64'(irq), 64'h0);

        // R6: read-only offsets ignore writes
        wr(12'h300, 64'hDEAD_BEEF_0000_0000, e);
        chk(e == 1'b0, "R6 raw write no err", 64'(e), 64'h0);
        wr(12'h280, 64'hFFFF, e);
        chk(e == 1'b0, "R6 masked write no err", 64'(e), 64'h0);
        rd(12'h300, raw_of(dev, leg), 1'b0, "R6 raw unchanged");
        check_masks("R6 masks unchanged");

        // R7: unimplemented offsets
        rd(12'h204, '1, 1'b1, "R7 read 0x204");
        rd(12'h000, '1, 1'b1, "R7 read 0x000");
        wr(12'h208, 64'hFFFF, e);
        chk(e == 1'b1, "R7 write err", 64'(e), 64'h1);
        check_masks("R7 masks untouched");

        // R8: read data holds, error drops
        rd(12'h240, mask_m[1], 1'b0, "R8 read mask1");
        rd(12'h3FC, '1, 1'b1, "R8 bad read");
        @(negedge clk);
        chk(err == 1'b0, "R8 err one cycle", 64'(err), 64'h0);
        chk(rdata == '1, "R8 rdata held", rdata, '1);

        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule